// File: doc/BRIEF.md
# Accumulating Compare Flag Generator

This block keeps three sticky comparison flags and two per-result flags, which are updated from the outcome of each compare or subtract. It does not compute the arithmetic result. It only receives indications about that result: the sign, an overflow bit, a zero bit, a NaN bit and an operand-equality bit. A mode input chooses which rule set applies. Signed fixed-point rules use the sign and the overflow bit. Floating-point rules use the result class (NaN, zero, sign).

The three sticky flags are `all_ge_o`, `all_lt_o` and `in_range_o`. A start pulse sets all three to 1. After that, results can only clear them. Software runs a sequence of compares and then reads the flags, which give an all-pass or any-fail answer for the whole sequence. `in_range_o` is cleared only when `all_lt_o` was still set before the current result. This lets a two-sided bounds check accumulate in one flag. `cmp_neg_o` and `cmp_eq_o` describe only the most recent floating-point result.

Top module: `cmp_flag_accum`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, all five flag outputs become 0.
- R2: `start_i` high at a rising edge sets `all_ge_o`, `all_lt_o` and `in_range_o` to 1. This takes priority over any update from `valid_i` in the same cycle.
- R3: In fixed-point mode (`mode_fp_i`=0), an accepted result clears `all_ge_o` when `sgn_i` XOR `ovf_i` is 1. If that is 0, `all_ge_o` keeps its value.
- R4: In fixed-point mode, an accepted result clears `all_lt_o` when `sgn_i` XOR `ovf_i` is 0. If that is 1, `all_lt_o` keeps its value.
- R5: In fixed-point mode, an accepted result clears `in_range_o` only when `all_lt_o` was 1 before this update and `sgn_i` XOR `ovf_i` is 1.
- R6: In floating-point mode (`mode_fp_i`=1), an accepted result clears `all_ge_o` when `nan_i` is 1, or when `sgn_i`=1 and `zero_i`=0.
- R7: In floating-point mode, an accepted result clears `all_lt_o` when `sgn_i`=0, `zero_i`=1 or `nan_i`=1.
- R8: In floating-point mode, an accepted result clears `in_range_o` when `nan_i` is 1. It also clears `in_range_o` when `sgn_i`=1, `zero_i`=0 and `all_lt_o` was 1 before this update.
- R9: In floating-point mode, an accepted result loads `cmp_neg_o` with (`nan_i` OR (`sgn_i` AND NOT `zero_i`)) and loads `cmp_eq_o` with `eq_i`.
- R10: In fixed-point mode, `cmp_neg_o` and `cmp_eq_o` keep their values.
- R11: `all_ge_o`, `all_lt_o` and `in_range_o` go from 0 to 1 only through `start_i`.
- R12: In a cycle with `valid_i` and `start_i` both low, all five flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Sets the three sticky flags to 1 |
| valid_i | input | 1 | Result indications are valid this cycle |
| mode_fp_i | input | 1 | 1 selects floating-point rules, 0 selects fixed-point rules |
| sgn_i | input | 1 | Sign of the result (1 = negative) |
| ovf_i | input | 1 | Fixed-point overflow of the result |
| zero_i | input | 1 | Floating-point result is zero |
| nan_i | input | 1 | Floating-point result is NaN |
| eq_i | input | 1 | The two source operands compare equal |
| all_ge_o | output | 1 | Sticky: no result was below zero |
| all_lt_o | output | 1 | Sticky: every result was below zero |
| in_range_o | output | 1 | Sticky bounds-check outcome |
| cmp_neg_o | output | 1 | Last floating-point result was negative or NaN |
| cmp_eq_o | output | 1 | Last floating-point operands were equal |

## Verification
Each flag is held in a single register, so every result appears on the outputs exactly one rising edge after the edge where `valid_i`, `start_i` or reset was sampled. The bench drives its inputs on falling edges. It advances its reference model at the same rising edge the design uses, and compares all five outputs at the next falling edge, before it drives new stimulus. Directed sequences come first: start with a simultaneous result, the dependency on the prior value of `all_lt_o`, and NaN versus signed zero. A seeded random stream follows, mixing modes and idle cycles.

// File: rtl/cmp_flag_pkg.sv
// Package: shared types for the compare flag generator.
// Assumes: the three sticky flags are always handled as a group.
package cmp_flag_pkg;

    // Group of the three sticky accumulating flags (or a clear mask for them).
    typedef struct packed {
        logic ge;
        logic lt;
        logic rng;
    } acc_flags_t;

    localparam acc_flags_t ACC_ALL_SET = '{ge: 1'b1, lt: 1'b1, rng: 1'b1};
    localparam acc_flags_t ACC_NONE    = '{ge: 1'b0, lt: 1'b0, rng: 1'b0};

endpackage

// File: rtl/cmp_fix_rules.sv
// Module: clear-mask rules for signed fixed-point results.
// Assumes: sgn_i and ovf_i describe the result of a two's complement
// subtraction. The true sign of the exact difference is their XOR.
// Purely combinational. lt_prev is the registered all_lt flag.
module cmp_fix_rules
    import cmp_flag_pkg::*;
(
    input  logic       sgn_i,
    input  logic       ovf_i,
    input  logic       lt_prev,
    output acc_flags_t clr_o
);
    logic true_neg;

    // Derive the true sign of the exact difference and the clear mask.
    always_comb begin
        true_neg  = sgn_i ^ ovf_i;
        clr_o.ge  = true_neg;
        clr_o.lt  = ~true_neg;
        clr_o.rng = lt_prev & true_neg;
    end
endmodule

// File: rtl/cmp_flt_rules.sv
// Module: clear-mask and per-result flag rules for floating-point results.
// Assumes: the result class is given as NaN, zero and sign. When nan_i is
// set, the sign and zero bits do not matter. Purely combinational.
module cmp_flt_rules
    import cmp_flag_pkg::*;
(
    input  logic       sgn_i,
    input  logic       zero_i,
    input  logic       nan_i,
    input  logic       lt_prev,
    output acc_flags_t clr_o,
    output logic       neg_o
);
    logic neg_nz;

    // Classify the result and form the clear mask and the negative flag.
    always_comb begin
        neg_nz    = sgn_i & ~zero_i;
        clr_o.ge  = nan_i | neg_nz;
        clr_o.lt  = nan_i | zero_i | ~sgn_i;
        clr_o.rng = nan_i | (neg_nz & lt_prev);
        neg_o     = nan_i | neg_nz;
    end
endmodule

// File: rtl/cmp_flag_regs.sv
// Module: flag storage. It holds the three sticky flags (set by start,
// cleared by the mask) and the two per-result floating-point flags.
// Assumes: the clear mask is already qualified by the mode. Synchronous
// active-low reset clears everything.
module cmp_flag_regs
    import cmp_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       valid_i,
    input  acc_flags_t clr_i,
    input  logic       cz_load_i,
    input  logic       neg_nxt_i,
    input  logic       eq_nxt_i,
    output acc_flags_t acc_o,
    output logic       neg_o,
    output logic       eq_o
);
    acc_flags_t acc_q;
    logic       neg_q;
    logic       eq_q;

    // Sticky flags: start sets them to 1, an accepted result can only clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= ACC_NONE;
        else if (start_i)
            acc_q <= ACC_ALL_SET;
        else if (valid_i)
            acc_q <= acc_q & ~clr_i;
    end

    // Per-result flags: loaded only for accepted floating-point results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            eq_q  <= 1'b0;
        end else if (cz_load_i) begin
            neg_q <= neg_nxt_i;
            eq_q  <= eq_nxt_i;
        end
    end

    assign acc_o = acc_q;
    assign neg_o = neg_q;
    assign eq_o  = eq_q;

    AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (acc_q == ACC_ALL_SET)); // R2
    AST_GE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !acc_q.ge) |=> !acc_q.ge); // R11
    AST_LT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !acc_q.lt) |=> !acc_q.lt); // R11
    AST_RNG_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !acc_q.rng) |=> !acc_q.rng); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !valid_i) |=> ($stable(acc_q) && $stable(neg_q) && $stable(eq_q))); // R12
endmodule

// File: rtl/cmp_flag_accum.sv
// Module: top of the accumulating compare flag generator. It runs both rule
// sets on every cycle, uses mode_fp_i to pick which clear mask applies,
// and passes the result to the flag storage.
// Assumes: result indications are valid only while valid_i is high.
// All outputs are registered with a latency of one edge.
module cmp_flag_accum
    import cmp_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic mode_fp_i,
    input  logic sgn_i,
    input  logic ovf_i,
    input  logic zero_i,
    input  logic nan_i,
    input  logic eq_i,
    output logic all_ge_o,
    output logic all_lt_o,
    output logic in_range_o,
    output logic cmp_neg_o,
    output logic cmp_eq_o
);
    acc_flags_t acc;
    acc_flags_t clr_fix;
    acc_flags_t clr_flt;
    acc_flags_t clr_sel;
    logic       neg_flt;
    logic       cz_load;

    cmp_fix_rules u_fix (
        .sgn_i   (sgn_i),
        .ovf_i   (ovf_i),
        .lt_prev (acc.lt),
        .clr_o   (clr_fix)
    );

    cmp_flt_rules u_flt (
        .sgn_i   (sgn_i),
        .zero_i  (zero_i),
        .nan_i   (nan_i),
        .lt_prev (acc.lt),
        .clr_o   (clr_flt),
        .neg_o   (neg_flt)
    );

    // Pick the rule set for the current mode and qualify the per-result load.
    always_comb begin
        clr_sel = mode_fp_i ? clr_flt : clr_fix;
        cz_load = valid_i & mode_fp_i;
    end

    cmp_flag_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .valid_i   (valid_i),
        .clr_i     (clr_sel),
        .cz_load_i (cz_load),
        .neg_nxt_i (neg_flt),
        .eq_nxt_i  (eq_i),
        .acc_o     (acc),
        .neg_o     (cmp_neg_o),
        .eq_o      (cmp_eq_o)
    );

    assign all_ge_o   = acc.ge;
    assign all_lt_o   = acc.lt;
    assign in_range_o = acc.rng;

    AST_FIX_RNG_NEEDS_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !mode_fp_i && !start_i && !all_lt_o) |=> $stable(in_range_o)); // R5
    AST_FP_NAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_fp_i && nan_i && !start_i) |=> (!all_ge_o && !all_lt_o && !in_range_o)); // R8
    AST_FP_NEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_fp_i) |=> (cmp_neg_o == $past(nan_i || (sgn_i && !zero_i)))); // R9
    AST_FP_EQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_fp_i) |=> (cmp_eq_o == $past(eq_i))); // R9
    AST_FIX_CZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fp_i) |=> ($stable(cmp_neg_o) && $stable(cmp_eq_o))); // R10
endmodule

// File: tb/tb_cmp_flag_accum.sv
`timescale 1ns/1ps
module tb_cmp_flag_accum;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, valid_i = 1'b0, mode_fp_i = 1'b0;
    logic sgn_i = 1'b0, ovf_i = 1'b0, zero_i = 1'b0, nan_i = 1'b0, eq_i = 1'b0;
    logic all_ge_o, all_lt_o, in_range_o, cmp_neg_o, cmp_eq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic m_ge = 1'b0, m_lt = 1'b0, m_rng = 1'b0, m_neg = 1'b0, m_eq = 1'b0;

    always #2 clk = ~clk;

    cmp_flag_accum dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .mode_fp_i(mode_fp_i), .sgn_i(sgn_i), .ovf_i(ovf_i), .zero_i(zero_i),
        .nan_i(nan_i), .eq_i(eq_i), .all_ge_o(all_ge_o), .all_lt_o(all_lt_o),
        .in_range_o(in_range_o), .cmp_neg_o(cmp_neg_o), .cmp_eq_o(cmp_eq_o)
    );

    // Which requirement governs a given flag under the current stimulus.
    function automatic string req_of(input int flag, input logic st, input logic v, input logic fp);
        if (!rst_n) return "R1";
        if (st && flag < 3) return "R2";
        if (!v && !st) return "R12";
        if (fp) begin
            case (flag)
                0: return "R6";
                1: return "R7";
                2: return "R8";
                default: return "R9";
            endcase
        end
        case (flag)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R10";
        endcase
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        logic tn, nnz, old_lt;
        old_lt = m_lt;
        if (!rst_n) begin
            {m_ge, m_lt, m_rng, m_neg, m_eq} <= 5'b0;
        end else begin
            nnz = sgn_i & ~zero_i;
            tn  = sgn_i ^ ovf_i;
            if (start_i) begin
                m_ge <= 1'b1; m_lt <= 1'b1; m_rng <= 1'b1;
            end else if (valid_i) begin
                if (mode_fp_i) begin
                    if (nan_i || nnz) m_ge <= 1'b0;
                    if (nan_i || zero_i || !sgn_i) m_lt <= 1'b0;
                    if (nan_i || (nnz && old_lt)) m_rng <= 1'b0;
                end else begin
                    if (tn) m_ge <= 1'b0;
                    if (!tn) m_lt <= 1'b0;
                    if (tn && old_lt) m_rng <= 1'b0;
                end
            end
            if (valid_i && mode_fp_i) begin
                m_neg <= nan_i | nnz;
                m_eq  <= eq_i;
            end
        end
    end

    task automatic check1(input string req, input string name, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, name, got, exp, $time);
        end
    endtask

    // Compare all outputs; the requirement tags come from the stimulus just applied.
    task automatic check_all(input logic st, input logic v, input logic fp, input logic r);
        string q;
        q = r ? "R1" : "";
        check1(r ? q : req_of(0, st, v, fp), "all_ge",   all_ge_o,   m_ge);
        check1(r ? q : req_of(1, st, v, fp), "all_lt",   all_lt_o,   m_lt);
        check1(r ? q : req_of(2, st, v, fp), "in_range", in_range_o, m_rng);
        check1(r ? q : req_of(3, st, v, fp), "cmp_neg",  cmp_neg_o,  m_neg);
        check1(r ? q : req_of(3, st, v, fp), "cmp_eq",   cmp_eq_o,   m_eq);
    endtask

    // Drive one cycle on the falling edge, check at the next falling edge.
    task automatic step(input logic st, input logic v, input logic fp, input logic s,
                        input logic o, input logic z, input logic n, input logic e);
        start_i = st; valid_i = v; mode_fp_i = fp;
        sgn_i = s; ovf_i = o; zero_i = z; nan_i = n; eq_i = e;
        @(negedge clk);
        check_all(st, v, fp, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_all(1'b0, 1'b0, 1'b0, 1'b1);          // R1 reset state
        rst_n = 1'b1;
        // R2: start plus simultaneous clearing result: start wins
        step(1, 1, 0, 1, 0, 0, 0, 0);
        // R5: lt set, true negative clears rng and ge
        step(0, 1, 0, 1, 0, 0, 0, 0);
        // R4: positive clears lt
        step(0, 1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        // R3/R4: negative sign with overflow counts as positive
        step(0, 1, 0, 1, 1, 0, 0, 0);
        // R5: lt now clear, true negative must leave rng set
        step(0, 1, 0, 0, 1, 0, 0, 0);
        // R10: fixed mode with eq high leaves cmp flags
        step(0, 1, 0, 0, 0, 0, 0, 1);
        // R8/R9: NaN clears all and sets cmp_neg
        step(1, 0, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 0, 0, 0, 1, 1);
        // R7/R9: negative zero: not negative, clears lt only
        step(1, 0, 1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 1, 1, 1, 0, 0);
        step(0, 1, 1, 1, 0, 0, 0, 1);           // R6/R8 negative nonzero, lt clear
        step(0, 0, 1, 0, 0, 0, 1, 0);           // R12 idle with NaN on inputs
        for (int i = 0; i < 3000; i++) begin
            logic st, v;
            st = ($urandom % 20) == 0;
            v  = ($urandom % 10) < 7;
            step(st, v, 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), (($urandom % 6) == 0), 1'($urandom));
        end
        // R1 mid-run reset
        rst_n = 1'b0; start_i = 1'b0; valid_i = 1'b0;
        @(negedge clk);
        check_all(1'b0, 1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule